// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management register file of a single Ethernet PHY, reached through two host-side registers. The host writes a command word (a read or write request plus a 5-bit PHY register number) into the command register. A small sequencer then carries out the access against the modelled PHY registers and clears the request bits when it is done. Write data travels in the low half of the host data register. Read results come back in its high half.

The modelled PHY holds these registers: basic control, basic status, two identifier words, the advertisement word, partner ability, expansion, an interrupt source register and an interrupt mask register. Each has fixed reset values and write masks. Enabling autonegotiation completes it at once. Reading the interrupt source register clears it. A link-state input drives status and interrupt bits, and a level interrupt output reports any unmasked source bit. The serial bit timing of a real management bus is not modelled.

The command sequencer has three states. `ST_IDLE` moves to `ST_ISSUE` on a host write to the command register that has a request bit set. `ST_ISSUE` always moves to `ST_RETIRE`, and the PHY access takes place on that transition. `ST_RETIRE` always returns to `ST_IDLE` and clears the request bits as it does so. The link tracker has two states. `LK_DOWN` moves to `LK_UP` when the link input is high, which is a link-up event. `LK_UP` moves to `LK_DOWN` when the input is low, which is a link-down event. A PHY soft reset forces the tracker back to `LK_DOWN`.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset, both host registers read 0, `busy` and `phy_irq` are low, and the PHY registers read: control 0x3000, status 0x7809, advertisement 0x01E1, interrupt source 0, interrupt mask 0.
- R2: `host_sel`=0 selects the command register and `host_sel`=1 selects the data register. In the command register, bit 27 requests a write, bit 26 requests a read, and bits [25:21] give the PHY register. A write request wins when both bits are set. `busy` is high for exactly the two cycles after the accepted command write. The request bits read back set during that time and read 0 afterwards, while the address field keeps its value.
- R3: A read places the 16-bit PHY value in data register bits [31:16] and leaves bits [15:0] unchanged. The result is visible no later than the cycle in which `busy` falls.
- R4: Register 2 reads 0x0007, register 3 reads 0xC0D1, register 5 reads 0x0F71 and register 6 reads 0x0001.
- R5: Writing register 0 with bit 15 clear stores the value ANDed with 0x7980. If bit 12 is also set, status bit 5 is set immediately.
- R6: Writing register 4 stores (value AND 0x2D7F) OR 0x0080. Writing register 30 stores the low 8 bits of the value.
- R7: Reading register 29 returns the source bits and then clears them. A link event in the same cycle as the read is not lost: its bits remain set after the clear.
- R8: A link-up event sets status bits 5 and 2 and source bits 7 and 6. A link-down event clears status bits 5 and 2 and sets source bit 4.
- R9: Registers not listed here read as 0. Writes to registers other than 0, 4 and 30 have no effect.
- R10: `phy_irq` is high exactly when the interrupt source ANDed with the mask is nonzero.
- R11: Host writes to either host register are ignored while `busy` is high.
- R12: Writing register 0 with bit 15 set returns control, status, advertisement, mask and source to their reset values. After that, a link input that is still high is reported as a fresh link-up event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the command register, 1 selects the data register |
| host_wdata | input | 32 | Host write data |
| ctl_reg | output | 32 | Current command register contents |
| data_reg | output | 32 | Current data register contents |
| busy | output | 1 | A PHY access is in progress |
| link_up | input | 1 | Link state seen by the PHY |
| phy_irq | output | 1 | Unmasked PHY interrupt pending |

## Verification
The assertions assume that `link_up` is a clean level that changes at most once per cycle. They also assume that events follow the tracker's registered state, so a rise and a fall never happen in the same cycle. The bench changes `link_up` only at falling clock edges and holds it for several cycles, except in one deliberate case that lines up a link-up event with a source-register read. The assertions also assume that only a command write starts an access. The bench therefore drives host writes only through its access tasks, plus one burst that is deliberately issued while busy to show it is ignored.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int HOST_BITS  = 32;
    localparam int PHY_ABITS  = 5;
    localparam int PHY_DBITS  = 16;
    localparam int SRC_BITS   = 8;
    localparam int REQ_RD_POS = 26;
    localparam int REQ_WR_POS = 27;
    localparam int REG_LSB    = 21;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RETIRE
    } cmd_state_t;

    typedef enum logic {
        LK_DOWN,
        LK_UP
    } link_state_t;

    localparam logic [4:0] RA_CTRL    = 5'd0;
    localparam logic [4:0] RA_STAT    = 5'd1;
    localparam logic [4:0] RA_IDA     = 5'd2;
    localparam logic [4:0] RA_IDB     = 5'd3;
    localparam logic [4:0] RA_ADV     = 5'd4;
    localparam logic [4:0] RA_PARTNER = 5'd5;
    localparam logic [4:0] RA_EXPAN   = 5'd6;
    localparam logic [4:0] RA_SRC     = 5'd29;
    localparam logic [4:0] RA_MSK     = 5'd30;

    localparam logic [15:0] CTRL_INIT  = 16'h3000;
    localparam logic [15:0] STAT_INIT  = 16'h7809;
    localparam logic [15:0] ADV_INIT   = 16'h01E1;
    localparam logic [15:0] IDA_VAL    = 16'h0007;
    localparam logic [15:0] IDB_VAL    = 16'hC0D1;
    localparam logic [15:0] PARTNER_VAL = 16'h0F71;
    localparam logic [15:0] EXPAN_VAL  = 16'h0001;

    localparam logic [15:0] CTRL_KEEP  = 16'h7980;
    localparam logic [15:0] ADV_KEEP   = 16'h2D7F;
    localparam logic [15:0] ADV_FORCE  = 16'h0080;
    localparam logic [15:0] LINK_STAT  = 16'h0024;
    localparam int          SOFT_RST_POS = 15;
    localparam int          AN_EN_POS    = 12;
    localparam int          AN_DONE_POS  = 5;

    localparam logic [7:0] SRC_LINK_UP   = 8'hC0;
    localparam logic [7:0] SRC_LINK_DOWN = 8'h10;

endpackage

// File: rtl/phy_mgmt_cmd_fsm.sv
module phy_mgmt_cmd_fsm
    import phy_mgmt_pkg::*;
#(
    parameter int HOST_W = HOST_BITS,
    parameter int AW     = PHY_ABITS,
    parameter int DW     = PHY_DBITS,
    parameter int RD_POS = REQ_RD_POS,
    parameter int WR_POS = REQ_WR_POS,
    parameter int A_LSB  = REG_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic [DW-1:0]     rd_value,
    output logic [HOST_W-1:0] ctl_q,
    output logic [HOST_W-1:0] dat_q,
    output logic              busy,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [AW-1:0]     acc_addr,
    output logic [DW-1:0]     acc_wdata
);

    cmd_state_t state_q, state_d;
    logic       ctl_wr, dat_wr, cmd_req;

    assign ctl_wr  = host_we && !host_sel && (state_q == ST_IDLE);
    assign dat_wr  = host_we &&  host_sel && (state_q == ST_IDLE);
    assign cmd_req = host_wdata[RD_POS] | host_wdata[WR_POS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ctl_wr && cmd_req) state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_RETIRE;
            ST_RETIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        acc_valid = (state_q == ST_ISSUE);
        acc_write = ctl_q[WR_POS];
        acc_addr  = ctl_q[A_LSB +: AW];
        acc_wdata = dat_q[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= host_wdata;
        end else if (state_q == ST_RETIRE) begin
            ctl_q[RD_POS] <= 1'b0;
            ctl_q[WR_POS] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else if (dat_wr) begin
            dat_q <= host_wdata;
        end else if (state_q == ST_ISSUE && !ctl_q[WR_POS]) begin
            dat_q[HOST_W-1 -: DW] <= rd_value;
        end
    end

endmodule

// File: rtl/phy_mgmt_link_evt.sv
module phy_mgmt_link_evt
    import phy_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic link_up,
    output logic rise,
    output logic fall
);

    link_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= LK_DOWN;
        else if (restart) state_q <= LK_DOWN;
        else              state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_DOWN: if (link_up)  state_d = LK_UP;
            LK_UP:   if (!link_up) state_d = LK_DOWN;
            default: state_d = LK_DOWN;
        endcase
    end

    always_comb begin
        rise = (state_q == LK_DOWN) && link_up;
        fall = (state_q == LK_UP)   && !link_up;
    end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int AW = PHY_ABITS,
    parameter int DW = PHY_DBITS,
    parameter int SW = SRC_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic          link_rise,
    input  logic          link_fall,
    output logic          soft_rst,
    output logic [DW-1:0] ctl_o,
    output logic [DW-1:0] stat_o,
    output logic [DW-1:0] adv_o,
    output logic [SW-1:0] src_o,
    output logic [SW-1:0] msk_o
);

    logic          wr_hit, rd_clr, ctl_hit;
    logic [DW-1:0] ctl_d, stat_d, adv_d;
    logic [SW-1:0] src_d, msk_d;

    assign wr_hit   = acc_valid && acc_write;
    assign ctl_hit  = wr_hit && (acc_addr == RA_CTRL);
    assign soft_rst = ctl_hit && acc_wdata[SOFT_RST_POS];
    assign rd_clr   = acc_valid && !acc_write && (acc_addr == RA_SRC);

    always_comb begin
        ctl_d  = ctl_o;
        stat_d = stat_o;
        adv_d  = adv_o;
        msk_d  = msk_o;
        if (ctl_hit) begin
            ctl_d = acc_wdata & CTRL_KEEP;
            if (acc_wdata[AN_EN_POS]) stat_d[AN_DONE_POS] = 1'b1;
        end
        if (wr_hit && acc_addr == RA_ADV) adv_d = (acc_wdata & ADV_KEEP) | ADV_FORCE;
        if (wr_hit && acc_addr == RA_MSK) msk_d = acc_wdata[SW-1:0];
        if (link_rise) stat_d = stat_d | LINK_STAT;
        if (link_fall) stat_d = stat_d & ~LINK_STAT;
        src_d = (rd_clr ? '0 : src_o)
              | (link_rise ? SRC_LINK_UP : '0)
              | (link_fall ? SRC_LINK_DOWN : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_o  <= CTRL_INIT;
            stat_o <= STAT_INIT;
            adv_o  <= ADV_INIT;
            src_o  <= '0;
            msk_o  <= '0;
        end else if (soft_rst) begin
            ctl_o  <= CTRL_INIT;
            stat_o <= STAT_INIT;
            adv_o  <= ADV_INIT;
            src_o  <= '0;
            msk_o  <= '0;
        end else begin
            ctl_o  <= ctl_d;
            stat_o <= stat_d;
            adv_o  <= adv_d;
            src_o  <= src_d;
            msk_o  <= msk_d;
        end
    end

endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
    import phy_mgmt_pkg::*;
#(
    parameter int HOST_W = HOST_BITS,
    parameter int AW     = PHY_ABITS,
    parameter int DW     = PHY_DBITS,
    parameter int SW     = SRC_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] ctl_reg,
    output logic [HOST_W-1:0] data_reg,
    output logic              busy,
    input  logic              link_up,
    output logic              phy_irq
);

    localparam int PAD = DW - SW;

    logic          acc_valid, acc_write;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata, rd_value;
    logic          link_rise, link_fall, soft_rst;
    logic [DW-1:0] phy_ctl_w, phy_stat_w, phy_adv_w;
    logic [SW-1:0] irq_src_w, irq_msk_w;

    phy_mgmt_cmd_fsm #(.HOST_W(HOST_W), .AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .rd_value(rd_value),
        .ctl_q(ctl_reg), .dat_q(data_reg), .busy(busy),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata)
    );

    phy_mgmt_link_evt u_link (
        .clk(clk), .rst_n(rst_n), .restart(soft_rst),
        .link_up(link_up), .rise(link_rise), .fall(link_fall)
    );

    phy_mgmt_regs #(.AW(AW), .DW(DW), .SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .link_rise(link_rise), .link_fall(link_fall),
        .soft_rst(soft_rst),
        .ctl_o(phy_ctl_w), .stat_o(phy_stat_w), .adv_o(phy_adv_w),
        .src_o(irq_src_w), .msk_o(irq_msk_w)
    );

    // Read multiplexer over the modelled PHY register space
    always_comb begin
        case (acc_addr)
            RA_CTRL:    rd_value = phy_ctl_w;
            RA_STAT:    rd_value = phy_stat_w;
            RA_IDA:     rd_value = IDA_VAL;
            RA_IDB:     rd_value = IDB_VAL;
            RA_ADV:     rd_value = phy_adv_w;
            RA_PARTNER: rd_value = PARTNER_VAL;
            RA_EXPAN:   rd_value = EXPAN_VAL;
            RA_SRC:     rd_value = {{PAD{1'b0}}, irq_src_w};
            RA_MSK:     rd_value = {{PAD{1'b0}}, irq_msk_w};
            default:    rd_value = '0;
        endcase
    end

    assign phy_irq = |(irq_src_w & irq_msk_w);

endmodule

// File: rtl/phy_mgmt_checks.sv
module phy_mgmt_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic [31:0] ctl_reg,
    input logic        phy_irq,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [4:0]  acc_addr,
    input logic        link_rise,
    input logic        link_fall,
    input logic        soft_rst,
    input logic [15:0] phy_ctl,
    input logic [15:0] phy_stat,
    input logic [15:0] phy_adv,
    input logic [7:0]  irq_src,
    input logic [7:0]  irq_msk
);

    p_req_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (ctl_reg[27:26] == 2'b00));

    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    p_ctl_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ctl & ~16'h7980) == 16'h0000);

    p_adv_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phy_adv[7] && ((phy_adv & ~16'h2DFF) == 16'h0000));

    p_src_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr == 5'd29 && !link_rise && !link_fall)
        |=> (irq_src == 8'h00));

    p_link_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rise && !soft_rst) |=> (phy_stat[5] && phy_stat[2] && irq_src[7] && irq_src[6]));

    p_link_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_fall && !soft_rst) |=> (!phy_stat[5] && !phy_stat[2] && irq_src[4]));

    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_msk == 8'h00) |-> !phy_irq);

    p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (phy_ctl == 16'h3000 && phy_adv == 16'h01E1 && irq_msk == 8'h00));

endmodule

bind phy_mgmt_model phy_mgmt_checks u_checks (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ctl_reg(ctl_reg), .phy_irq(phy_irq),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .link_rise(link_rise), .link_fall(link_fall), .soft_rst(soft_rst),
    .phy_ctl(phy_ctl_w), .phy_stat(phy_stat_w), .phy_adv(phy_adv_w),
    .irq_src(irq_src_w), .irq_msk(irq_msk_w)
);

// File: tb/phy_mgmt_model_test.sv
module phy_mgmt_model_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        link_up = 1'b0;
    logic [31:0] ctl_reg, data_reg;
    logic        busy, phy_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        rd;
        logic [4:0]  addr;
        logic [15:0] hi;
        logic [15:0] lo;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [15:0] cur_lo = 16'h0000;

    always #2 clk = ~clk;

    phy_mgmt_model uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .ctl_reg(ctl_reg), .data_reg(data_reg),
        .busy(busy), .link_up(link_up), .phy_irq(phy_irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: each completed access pops one expected item
    logic busy_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && busy_prev && !busy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected completion", ctl_reg, 32'h0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(ctl_reg[27:26] == 2'b00 && ctl_reg[25:21] == e.addr,
                      "R2 request cleared", ctl_reg, {6'h0, e.addr, 21'h0});
                if (e.rd)
                    check(data_reg == {e.hi, e.lo}, t, data_reg, {e.hi, e.lo});
                else
                    check(data_reg[15:0] == e.lo, t, {16'h0, data_reg[15:0]}, {16'h0, e.lo});
            end
        end
        busy_prev = busy;
    end

    // All tasks start and end at a falling edge
    task automatic host_write(input logic sel, input logic [31:0] d);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic mii_read(input logic [4:0] a, input logic [15:0] v, input string tag);
        exp_t e;
        e.rd = 1'b1; e.addr = a; e.hi = v; e.lo = cur_lo;
        exp_q.push_back(e); tag_q.push_back(tag);
        host_write(1'b0, (32'h1 << 26) | ({27'h0, a} << 21));
        check(busy && ctl_reg[26], "R2 busy with request set", ctl_reg, 32'h0400_0000);
        repeat (3) @(negedge clk);
    endtask

    task automatic mii_write(input logic [4:0] a, input logic [15:0] v, input logic [1:0] req, input string tag);
        exp_t e;
        host_write(1'b1, {16'h0, v});
        cur_lo = v;
        e.rd = 1'b0; e.addr = a; e.hi = 16'h0; e.lo = v;
        exp_q.push_back(e); tag_q.push_back(tag);
        host_write(1'b0, ({30'h0, req} << 26) | ({27'h0, a} << 21));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ctl_reg == 0 && data_reg == 0, "R1 host regs", ctl_reg | data_reg, 0);
        check(!busy && !phy_irq, "R1 busy/irq", {busy, phy_irq}, 0);
        mii_read(5'd0,  16'h3000, "R1 control");
        mii_read(5'd1,  16'h7809, "R1 status");
        mii_read(5'd4,  16'h01E1, "R1 advertise");
        mii_read(5'd29, 16'h0000, "R1 source");
        mii_read(5'd30, 16'h0000, "R1 mask");

        // R4 fixed values
        mii_read(5'd2, 16'h0007, "R4 id a");
        mii_read(5'd3, 16'hC0D1, "R4 id b");
        mii_read(5'd5, 16'h0F71, "R4 partner");
        mii_read(5'd6, 16'h0001, "R4 expansion");

        // R9 unmodelled space and read-only registers
        mii_read(5'd7,  16'h0000, "R9 reg7");
        mii_read(5'd31, 16'h0000, "R9 reg31");
        mii_write(5'd1, 16'hFFFF, 2'b10, "R9 status write");
        mii_read(5'd1, 16'h7809, "R9 status unchanged");
        mii_write(5'd2, 16'h1234, 2'b10, "R9 id write");
        mii_read(5'd2, 16'h0007, "R9 id unchanged");
        mii_write(5'd17, 16'h5A5A, 2'b10, "R9 reg17 write");
        mii_read(5'd17, 16'h0000, "R9 reg17 unchanged");

        // R3 read keeps low half; R5 control writes
        mii_write(5'd0, 16'h0100, 2'b10, "R5 write");
        mii_read(5'd0, 16'h0100, "R3 R5 control stored");
        mii_read(5'd1, 16'h7809, "R5 no autoneg");
        mii_write(5'd0, 16'h7FFF, 2'b10, "R5 write masked");
        mii_read(5'd0, 16'h7980, "R5 control masked");
        mii_read(5'd1, 16'h7829, "R5 autoneg done");

        // R6 advertisement and mask
        mii_write(5'd4, 16'hFFFF, 2'b10, "R6 adv");
        mii_read(5'd4, 16'h2DFF, "R6 adv all ones");
        mii_write(5'd4, 16'h0000, 2'b10, "R6 adv");
        mii_read(5'd4, 16'h0080, "R6 adv zero");
        mii_write(5'd30, 16'h1234, 2'b10, "R6 mask");
        mii_read(5'd30, 16'h0034, "R6 mask low byte");

        // R8 link up, R10 masked out
        link_up = 1'b1;
        repeat (3) @(negedge clk);
        check(!phy_irq, "R10 masked link-up", {31'h0, phy_irq}, 0);
        mii_read(5'd1, 16'h782D, "R8 status up");
        mii_read(5'd29, 16'h00C0, "R7 R8 source up");
        mii_read(5'd29, 16'h0000, "R7 cleared");

        // R8 link down, R10 unmasked
        link_up = 1'b0;
        repeat (3) @(negedge clk);
        check(phy_irq, "R10 link-down irq", {31'h0, phy_irq}, 1);
        mii_read(5'd1, 16'h7809, "R8 status down");
        mii_read(5'd29, 16'h0010, "R8 source down");
        check(!phy_irq, "R10 irq after clear", {31'h0, phy_irq}, 0);

        // R7 link event coincident with the clearing read
        begin
            exp_t e;
            e.rd = 1'b1; e.addr = 5'd29; e.hi = 16'h0000; e.lo = cur_lo;
            exp_q.push_back(e); tag_q.push_back("R7 read during event");
            host_write(1'b0, (32'h1 << 26) | (32'd29 << 21));
            link_up = 1'b1;
            repeat (3) @(negedge clk);
        end
        mii_read(5'd29, 16'h00C0, "R7 event kept");

        // R2 both request bits: write wins
        mii_write(5'd30, 16'h0055, 2'b11, "R2 both bits");
        mii_read(5'd30, 16'h0055, "R2 write won");

        // R11 writes while busy are ignored
        begin
            exp_t e;
            e.rd = 1'b1; e.addr = 5'd2; e.hi = 16'h0007; e.lo = cur_lo;
            exp_q.push_back(e); tag_q.push_back("R11 data untouched");
            host_write(1'b0, (32'h1 << 26) | (32'd2 << 21));
            host_write(1'b0, (32'h1 << 27) | (32'd30 << 21));
            host_write(1'b1, 32'h0000_ABCD);
            repeat (2) @(negedge clk);
        end
        mii_read(5'd30, 16'h0055, "R11 mask untouched");

        // R12 soft reset with link still up
        mii_write(5'd0, 16'h8000, 2'b10, "R12 soft reset");
        repeat (2) @(negedge clk);
        mii_read(5'd0,  16'h3000, "R12 control");
        mii_read(5'd4,  16'h01E1, "R12 advertise");
        mii_read(5'd30, 16'h0000, "R12 mask");
        mii_write(5'd30, 16'h0040, 2'b10, "R10 mask");
        check(phy_irq, "R10 R12 fresh link-up irq", {31'h0, phy_irq}, 1);
        mii_read(5'd1,  16'h782D, "R12 status relinked");
        mii_read(5'd29, 16'h00C0, "R12 source relinked");
        check(!phy_irq, "R10 irq cleared", {31'h0, phy_irq}, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all accesses completed", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule